// File: doc/BRIEF.md
# Dual-Lane Parallel Flash Erase Controller

This block is a host-side sequencer that erases two byte-wide flash devices at once. The two devices share one 16-bit bus: the low byte reaches one device and the high byte the other. The controller issues erase command words and waits out a programmable erase pulse. It then writes a verify command carrying the current address and reads back the 16-bit word. Each byte lane is judged on its own.

A lane that reads back fully erased at the current address is masked. From then on it receives the neutral byte FFH in place of its erase and verify command bytes, so it gets no further erase pulses while its partner keeps erasing. When both lanes pass, the address steps forward and the masks clear. The next address starts with a verify, not an erase.

The walk ends after the programmed last address passes, or when an address needs more erase loops than the limit allows. In both cases the controller writes the read-mode word 0000H and then raises done. The erase pulse length and the loop limit are parameters.

Top module: `pe_dual_erase`

## Requirements
- R1: After reset, wr_o, rd_o, done_o and err_o are low, wdata_o is 0000H and addr_o is 0.
- R2: When start_i is seen while idle or done, the controller writes 2020H on two consecutive cycles. It then holds both strobes low for exactly PULSE_CYC cycles.
- R3: After the erase pulse, the controller writes one verify word at the current address, with A0H in each unmasked lane. The next cycle is a single read cycle at the same address.
- R4: A lane passes when its byte of rdata_i (low lane bits 7:0, high lane bits 15:8) equals FFH in the read cycle. A passed lane gets FFH instead of 20H or A0H in every later erase and verify word at that address, for example 20FFH and A0FFH when only the low lane has passed.
- R5: If either lane has not passed after a read, the erase pair is written again and addr_o stays unchanged.
- R6: When both lanes have passed and the address is below last_addr_i, addr_o increments by one and both masks clear. The next write is a verify word A0A0H at the new address, with no erase in between.
- R7: When both lanes pass at last_addr_i, the controller writes 0000H once and then holds done_o high with err_o low.
- R8: An address may receive at most MAX_LOOPS erase loops. A failed read after the MAX_LOOPS-th loop writes 0000H, then sets done_o and err_o high.
- R9: start_i has no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an erase run from address 0 |
| last_addr_i | input | AW | Last address to verify, sampled at start |
| addr_o | output | AW | Bus address |
| wdata_o | output | 16 | Command word, low byte to the low lane |
| wr_o | output | 1 | Write strobe, one cycle per word |
| rd_o | output | 1 | Read strobe; rdata_i is sampled in this cycle |
| rdata_i | input | 16 | Read data from both devices |
| done_o | output | 1 | Run finished, held until the next start |
| err_o | output | 1 | Loop limit exceeded in the last run |

## Verification
In a single read cycle, one lane can pass while the other fails. One lane's mask then sets in the same cycle that the erase loop restarts for its partner. Alternatively, the second lane can pass, so the address steps and both masks clear in the same edge. The bench provokes both cases by giving the lanes different erase requirements, at ordinary addresses and at the last one. It judges the result by the erase pulses each modelled device actually receives, by the verify-word count, and by whether the masked command words 20FFH and A0FFH appear on the bus.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int LANES = 2;
  localparam int BW    = 8;

  localparam logic [BW-1:0] ERS_BYTE   = 8'h20;
  localparam logic [BW-1:0] VFY_BYTE   = 8'hA0;
  localparam logic [BW-1:0] MASK_BYTE  = 8'hFF;
  localparam logic [BW-1:0] READ_BYTE  = 8'h00;
  localparam logic [BW-1:0] CLEAN_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERS_A, ST_ERS_B, ST_PULSE, ST_VFY, ST_RD, ST_EXIT, ST_DONE
  } pe_state_t;

  typedef enum logic [1:0] {OP_READ, OP_ERS, OP_VFY} pe_op_t;
endpackage

// File: rtl/pe_pulse_timer.sv
module pe_pulse_timer #(
  parameter int CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + CW'(1);
  end

  assign expire_o = run_i && (cnt_q == CW'(CYC - 1));

  // R2: the pulse needs at least one earlier run cycle before it expires
  p_pulse_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(run_i));
endmodule

// File: rtl/pe_lane_mask.sv
module pe_lane_mask
  import pe_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                eval_i,
  input  logic [LANES*BW-1:0] rd_data_i,
  output logic [LANES-1:0]    mask_o,
  output logic                all_pass_o
);
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l] = (rd_data_i[l*BW +: BW] == CLEAN_BYTE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_q[l] <= 1'b0;
      else if (clr_i)  mask_q[l] <= 1'b0;
      else if (eval_i) mask_q[l] <= mask_q[l] | hit[l];
    end

    // R4: a passed lane stays masked until the address advances
    p_mask_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q[l] && !clr_i) |=> mask_q[l]);
  end

  assign mask_o     = mask_q;
  assign all_pass_o = &(mask_q | hit);
endmodule

// File: rtl/pe_cmd_word.sv
module pe_cmd_word
  import pe_pkg::*;
(
  input  pe_op_t              op_i,
  input  logic [LANES-1:0]    mask_i,
  output logic [LANES*BW-1:0] word_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (op_i)
        OP_ERS:  word_o[l*BW +: BW] = mask_i[l] ? MASK_BYTE : ERS_BYTE;
        OP_VFY:  word_o[l*BW +: BW] = mask_i[l] ? MASK_BYTE : VFY_BYTE;
        default: word_o[l*BW +: BW] = READ_BYTE;
      endcase
    end
  end
endmodule

// File: rtl/pe_dual_erase.sv
module pe_dual_erase
  import pe_pkg::*;
#(
  parameter int AW        = 17,
  parameter int PULSE_CYC = 1000000,
  parameter int MAX_LOOPS = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] last_addr_i,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   wdata_o,
  output logic          wr_o,
  output logic          rd_o,
  input  logic [15:0]   rdata_i,
  output logic          done_o,
  output logic          err_o
);
  localparam int LW = $clog2(MAX_LOOPS + 1);

  pe_state_t        state_q, state_d;
  logic [AW-1:0]    addr_q, last_q;
  logic [LW-1:0]    loops_q;
  logic             err_q;
  logic             expire, all_pass, accept, step, at_last, give_up;
  logic [LANES-1:0] mask;
  pe_op_t           op;

  pe_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_PULSE),
    .expire_o (expire)
  );

  pe_lane_mask u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept || step),
    .eval_i     (state_q == ST_RD),
    .rd_data_i  (rdata_i),
    .mask_o     (mask),
    .all_pass_o (all_pass)
  );

  pe_cmd_word u_cmd (
    .op_i   (op),
    .mask_i (mask),
    .word_o (wdata_o)
  );

  assign accept  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign at_last = (addr_q == last_q);
  assign step    = (state_q == ST_RD) && all_pass && !at_last;
  assign give_up = (state_q == ST_RD) && !all_pass && (loops_q == LW'(MAX_LOOPS));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (accept) state_d = ST_ERS_A;
      ST_ERS_A:         state_d = ST_ERS_B;
      ST_ERS_B:         state_d = ST_PULSE;
      ST_PULSE:         if (expire) state_d = ST_VFY;
      ST_VFY:           state_d = ST_RD;
      ST_RD: begin
        if (all_pass)     state_d = at_last ? ST_EXIT : ST_VFY;
        else if (give_up) state_d = ST_EXIT;
        else              state_d = ST_ERS_A;
      end
      ST_EXIT:          state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      last_q  <= '0;
      loops_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= '0;
        last_q  <= last_addr_i;
        loops_q <= '0;
        err_q   <= 1'b0;
      end else if (state_q == ST_ERS_A) begin
        loops_q <= loops_q + LW'(1);
      end else if (step) begin
        addr_q  <= addr_q + AW'(1);
        loops_q <= '0;
      end else if (give_up) begin
        err_q   <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ERS_A, ST_ERS_B: op = OP_ERS;
      ST_VFY:             op = OP_VFY;
      default:            op = OP_READ;
    endcase
  end

  assign addr_o = addr_q;
  assign wr_o   = (state_q == ST_ERS_A) || (state_q == ST_ERS_B) ||
                  (state_q == ST_VFY)   || (state_q == ST_EXIT);
  assign rd_o   = (state_q == ST_RD);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = err_q;

  // R2: the erase word is always written twice back to back
  p_erase_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERS_A) |=> (wr_o && wdata_o == $past(wdata_o)));

  // R3: a verify write is followed by a read at the same address
  p_vfy_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VFY) |=> (rd_o && addr_o == $past(addr_o)));

  // R5: a failed read keeps the address
  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && !all_pass) |=> $stable(addr_o));

  // R6: inside a run the address only moves up by one
  p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DONE && $past(state_q) != ST_DONE && $past(state_q) != ST_IDLE &&
     addr_o != $past(addr_o)) |-> addr_o == $past(addr_o) + AW'(1));

  // R7: done is entered only after a 0000H write
  p_exit_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(wr_o) && $past(wdata_o) == 16'h0000));

  // R8: the loop counter never passes the limit
  p_loop_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loops_q <= LW'(MAX_LOOPS));
endmodule

// File: tb/sim_pe_dual_erase.sv
module sim_pe_dual_erase;
  localparam int AW  = 4;
  localparam int PC  = 6;
  localparam int ML  = 4;
  localparam int NA  = 1 << AW;
  localparam int NV  = 7;

  // last, lo_base, lo_spike_addr, lo_spike, hi_base, hi_spike_addr, hi_spike
  localparam int VEC [NV][7] = '{
    '{3, 1, 15, 0, 1, 15, 0},
    '{5, 1, 2, 2, 2, 15, 0},
    '{0, 3, 0, 0, 1, 0, 0},
    '{15, 1, 15, 1, 2, 7, 1},
    '{4, 1, 3, 5, 1, 15, 0},
    '{2, 4, 0, 0, 4, 0, 0},
    '{2, 1, 0, 0, 5, 0, 0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] last_addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [15:0]   wdata_o, rdata_i;
  logic          wr_o, rd_o, done_o, err_o;

  int n_chk = 0, n_err = 0;
  int need_lo [NA];
  int need_hi [NA];
  int p_lo, p_hi, n_vfy;
  logic [7:0] prev_lo, prev_hi;
  logic [15:0] last_wr;
  bit saw_20ff, saw_a0ff, model_clr;

  always #2 clk_i = ~clk_i;

  pe_dual_erase #(.AW(AW), .PULSE_CYC(PC), .MAX_LOOPS(ML)) u0 (
    .clk_i, .rst_ni, .start_i, .last_addr_i, .addr_o, .wdata_o,
    .wr_o, .rd_o, .rdata_i, .done_o, .err_o
  );

  assign rdata_i = {(p_hi >= need_hi[addr_o]) ? 8'hFF : 8'h00,
                    (p_lo >= need_lo[addr_o]) ? 8'hFF : 8'h00};

  always @(posedge clk_i) begin
    if (model_clr) begin
      p_lo <= 0; p_hi <= 0; n_vfy <= 0; prev_lo <= 8'h00; prev_hi <= 8'h00;
      saw_20ff <= 1'b0; saw_a0ff <= 1'b0; last_wr <= 16'hxxxx;
    end else if (wr_o) begin
      if (wdata_o[7:0] == 8'h20 && prev_lo == 8'h20) begin p_lo <= p_lo + 1; prev_lo <= 8'h00; end
      else prev_lo <= wdata_o[7:0];
      if (wdata_o[15:8] == 8'h20 && prev_hi == 8'h20) begin p_hi <= p_hi + 1; prev_hi <= 8'h00; end
      else prev_hi <= wdata_o[15:8];
      if (wdata_o[7:0] == 8'hA0 || wdata_o[15:8] == 8'hA0) n_vfy <= n_vfy + 1;
      if (wdata_o == 16'h20FF) saw_20ff <= 1'b1;
      if (wdata_o == 16'hA0FF) saw_a0ff <= 1'b1;
      last_wr <= wdata_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input int v);
    for (int a = 0; a < NA; a++) begin
      need_lo[a] = VEC[v][1] + ((a == VEC[v][2]) ? VEC[v][3] : 0);
      need_hi[a] = VEC[v][4] + ((a == VEC[v][5]) ? VEC[v][6] : 0);
    end
    last_addr_i = AW'(VEC[v][0]);
  endtask

  // Expected outcome worked out from the requirements
  task automatic predict(output int e_err, output int e_lo, output int e_hi, output int e_vfy);
    int loops;
    bit m_lo, m_hi;
    e_err = 0; e_lo = 1; e_hi = 1; e_vfy = 0;
    for (int a = 0; a <= int'(last_addr_i) && e_err == 0; a++) begin
      loops = (a == 0) ? 1 : 0;
      m_lo = 0; m_hi = 0;
      forever begin
        e_vfy++;
        m_lo = m_lo || (e_lo >= need_lo[a]);
        m_hi = m_hi || (e_hi >= need_hi[a]);
        if (m_lo && m_hi) break;
        if (loops == ML) begin e_err = 1; break; end
        if (!m_lo) e_lo++;
        if (!m_hi) e_hi++;
        loops++;
      end
    end
  endtask

  task automatic fire_start;
    model_clr = 1'b1;
    @(negedge clk_i);
    model_clr = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done;
    int c = 0;
    while (!done_o && c < 20000) begin @(negedge clk_i); c++; end
    if (!done_o) check("watchdog", 0, 1);
  endtask

  task automatic run_vec(input int v, input bit poke);
    int e_err, e_lo, e_hi, e_vfy;
    load(v);
    predict(e_err, e_lo, e_hi, e_vfy);
    fire_start();
    if (poke) begin
      repeat (4) @(negedge clk_i);
      start_i = 1'b1; last_addr_i = '0;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_done();
    check(e_err ? "R8 err" : "R7 err", int'(err_o), e_err);
    check("R4 lo pulses", p_lo, e_lo);
    check("R4 hi pulses", p_hi, e_hi);
    check("R6 verify count", n_vfy, e_vfy);
    check("R7 exit word", int'(last_wr), 16'h0000);
    if (poke) check("R9 start ignored", p_lo + p_hi + n_vfy, e_lo + e_hi + e_vfy);
  endtask

  initial begin
    model_clr = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 wr", int'(wr_o), 0);
    check("R1 rd", int'(rd_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 err", int'(err_o), 0);
    check("R1 addr", int'(addr_o), 0);
    check("R1 wdata", int'(wdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2/R3 cycle trace on vector 1: low lane passes first, high lane fails
    load(1);
    fire_start();
    check("R2 erase word 1", int'(wr_o) << 16 | int'(wdata_o), 32'h1_2020);
    @(negedge clk_i);
    check("R2 erase word 2", int'(wr_o) << 16 | int'(wdata_o), 32'h1_2020);
    for (int i = 0; i < PC; i++) begin
      @(negedge clk_i);
      check("R2 pulse quiet", int'(wr_o | rd_o), 0);
    end
    @(negedge clk_i);
    check("R3 verify word", int'(wr_o) << 16 | int'(wdata_o), 32'h1_A0A0);
    check("R3 verify addr", int'(addr_o), 0);
    @(negedge clk_i);
    check("R3 read strobe", int'(rd_o), 1);
    check("R3 read addr", int'(addr_o), 0);
    @(negedge clk_i);
    check("R5 re-erase masked", int'(wr_o) << 16 | int'(wdata_o), 32'h1_20FF);
    check("R5 addr held", int'(addr_o), 0);
    wait_done();
    check("R4 saw 20FF", int'(saw_20ff), 1);
    check("R4 saw A0FF", int'(saw_a0ff), 1);
    check("R7 done", int'(done_o), 1);

    for (int v = 0; v < NV; v++) run_vec(v, 1'b0);
    run_vec(1, 1'b1);

    // R6: the step to the next address starts with a verify, no erase
    load(0);
    fire_start();
    while (!(rd_o && addr_o == 0)) @(negedge clk_i);
    @(negedge clk_i);
    check("R6 next verify", int'(wr_o) << 16 | int'(wdata_o), 32'h1_A0A0);
    check("R6 next addr", int'(addr_o), 1);
    wait_done();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule